// File: doc/BRIEF.md
# Underrun Sync-Fill Character Selector

This block sits in front of a synchronous serial transmitter and picks the character to be sent at each character slot. On every character-request strobe it sends the next byte from the data buffer when one is ready. When no byte is ready and a block, or a chain of blocks, is still open, it sends a programmed synchronization character instead. That keeps the character framing alive until data arrives again. The data bytes go out exactly as they arrived, and nothing in them is parsed, so line-control characters pass through untouched.

Software loads a small table of sync characters and the number of table entries in use. Fill characters are taken from the table in order and wrap around after the last entry in use. Each run of fill starts again at the first entry. If the programmed quantity is zero, the block sends the mark-idle character (all ones) instead and sets a sticky underrun flag. A saturating counter reports how many sync characters have been inserted. The block never puts fill in front of a block: while no block is open and no data is ready, a request produces nothing.

Top module: `sync_fill_inserter`

## Requirements
- R1: After reset, tx_valid is 0, fill_count is 0 and mark_idle_flag is 0.
- R2: When char_req and data_valid are both high in a cycle, data_pop is high in that same cycle. In the next cycle, tx_valid is high, tx_kind is DATA (2'd1) and tx_char equals the data_byte that was sampled.
- R3: Data bytes are sent unchanged whatever their value, including values equal to a table sync character, and whether block_active is high or low. Sending a data byte leaves fill_count unchanged.
- R4: When char_req is high, data_valid is low, block_active is high and the quantity in use is nonzero, the next cycle shows tx_valid high, tx_kind SYNC (2'd2) and a table character on tx_char.
- R5: Fill characters are taken from table entries 0, 1, … up to the quantity in use minus one, and then wrap back to entry 0.
- R6: Sending a data byte makes the next fill character come from entry 0.
- R7: When char_req is high and both data_valid and block_active are low, tx_valid stays low in the next cycle and fill_count does not change.
- R8: When the quantity in use is zero, a fill slot sends tx_kind MARK (2'd3) with tx_char all ones, and mark_idle_flag rises and stays high until reset.
- R9: fill_count rises by one for each SYNC character sent and saturates at its maximum value (255 by default).
- R10: Without char_req, tx_valid is low in the next cycle and data_pop is low.
- R11: cfg_char_we writes cfg_char into table entry cfg_char_idx. cfg_cnt_we loads the quantity in use and moves the next fill character back to entry 0.
- R12: A quantity written above the table depth (4 by default) is clamped to the table depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_char_we | input | 1 | Write strobe for one sync table entry |
| cfg_char_idx | input | 2 | Index of the table entry to write |
| cfg_char | input | 8 | Sync character to store |
| cfg_cnt_we | input | 1 | Write strobe for the quantity in use |
| cfg_cnt | input | 3 | Number of sync entries in use |
| char_req | input | 1 | Character-slot strobe from the transmitter |
| block_active | input | 1 | High while a block or chain of blocks is open |
| data_valid | input | 1 | Buffer holds a byte ready to send |
| data_byte | input | 8 | Byte at the head of the buffer |
| data_pop | output | 1 | Buffer head consumed this cycle |
| tx_valid | output | 1 | A character is presented this cycle |
| tx_kind | output | 2 | 0 none, 1 DATA, 2 SYNC, 3 MARK |
| tx_char | output | 8 | Character to serialize |
| mark_idle_flag | output | 1 | Sticky: mark fill has occurred |
| fill_count | output | 8 | Saturating count of inserted sync characters |

## Verification
A table-pointer error shows up on the very next fill slot as the wrong sync character, and every wrapping run checks the order again. If the pointer is not moved back after data or after a quantity load, the first fill of the next run comes out with the wrong character. Errors in the request decode show one cycle after the strobe: a wrong tx_kind, a character appearing with no block open, or a data_pop with no request. The fill counter and the sticky flag are compared after every cycle, so a missed increment or a failure to saturate is caught within one cycle.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_DATA = 2'd1,
        K_SYNC = 2'd2,
        K_MARK = 2'd3
    } chr_kind_e;

    function automatic int unsigned clamp_qty(input int unsigned q, input int unsigned depth);
        return (q > depth) ? depth : q;
    endfunction
endpackage

// File: rtl/sfi_sync_table.sv
module sfi_sync_table #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_char,
    input  logic          qty_we,
    input  logic [CW-1:0] qty_in,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_char,
    output logic [CW-1:0] qty
);
    logic [DW-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                entry[g] <= wr_char;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            qty <= '0;
        else if (qty_we)
            qty <= CW'(sfi_pkg::clamp_qty(int'(qty_in), DEPTH));
    end

    assign rd_char = entry[rd_idx];

    // R12
    qty_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        qty_we |=> (int'(qty) <= DEPTH));
endmodule

// File: rtl/sfi_fill_counter.sv
module sfi_fill_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && (count != {W{1'b1}}))
            count <= count + 1'b1;
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && (count != {W{1'b1}})) |=> (count == $past(count) + 1'b1));
    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc || (count == {W{1'b1}})) |=> $stable(count));
endmodule

// File: rtl/sfi_select.sv
module sfi_select
    import sfi_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          char_req,
    input  logic          data_valid,
    input  logic [DW-1:0] data_byte,
    input  logic          block_active,
    input  logic [CW-1:0] qty,
    input  logic [DW-1:0] sync_char,
    input  logic          ptr_clear,
    output logic [IW-1:0] rd_idx,
    output logic          data_pop,
    output logic          fill_sync,
    output logic          tx_valid,
    output chr_kind_e     tx_kind,
    output logic [DW-1:0] tx_char,
    output logic          mark_flag
);
    logic fill, fill_mark;
    logic [IW-1:0] ptr;

    always_comb begin
        data_pop  = char_req && data_valid;
        fill      = char_req && !data_valid && block_active;
        fill_sync = fill && (qty != '0);
        fill_mark = fill && (qty == '0);
    end

    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid  <= 1'b0;
            tx_kind   <= K_IDLE;
            tx_char   <= '0;
            ptr       <= '0;
            mark_flag <= 1'b0;
        end else begin
            tx_valid <= data_pop || fill;
            if (data_pop) begin
                tx_kind <= K_DATA;
                tx_char <= data_byte;
            end else if (fill_sync) begin
                tx_kind <= K_SYNC;
                tx_char <= sync_char;
            end else if (fill_mark) begin
                tx_kind <= K_MARK;
                tx_char <= {DW{1'b1}};
            end else begin
                tx_kind <= K_IDLE;
            end
            if (ptr_clear || data_pop)
                ptr <= '0;
            else if (fill_sync)
                ptr <= ((CW'(ptr) + 1'b1) >= qty) ? '0 : ptr + 1'b1;
            if (fill_mark)
                mark_flag <= 1'b1;
        end
    end

    // R2
    data_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (char_req && data_valid) |=> (tx_valid && tx_kind == K_DATA && tx_char == $past(data_byte)));
    // R7
    no_lead_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (char_req && !data_valid && !block_active) |=> !tx_valid);
    // R10
    quiet_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !char_req |=> !tx_valid);
    // R8
    mark_char_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == K_MARK) |-> (tx_char == {DW{1'b1}} && mark_flag));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mark_flag |=> mark_flag);
    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (qty != '0 && !ptr_clear) |=> (CW'(ptr) < qty || $past(qty) != qty));
endmodule

// File: rtl/sync_fill_inserter.sv
module sync_fill_inserter
    import sfi_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int CNT_W = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_char_we,
    input  logic [IW-1:0]    cfg_char_idx,
    input  logic [DW-1:0]    cfg_char,
    input  logic             cfg_cnt_we,
    input  logic [CW-1:0]    cfg_cnt,
    input  logic             char_req,
    input  logic             block_active,
    input  logic             data_valid,
    input  logic [DW-1:0]    data_byte,
    output logic             data_pop,
    output logic             tx_valid,
    output logic [1:0]       tx_kind,
    output logic [DW-1:0]    tx_char,
    output logic             mark_idle_flag,
    output logic [CNT_W-1:0] fill_count
);
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] rd_char;
    logic [CW-1:0] qty;
    logic          fill_sync;
    chr_kind_e     kind;

    sfi_sync_table #(.DW(DW), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(cfg_char_we), .wr_idx(cfg_char_idx), .wr_char(cfg_char),
        .qty_we(cfg_cnt_we), .qty_in(cfg_cnt),
        .rd_idx(rd_idx), .rd_char(rd_char), .qty(qty)
    );

    sfi_select #(.DW(DW), .DEPTH(DEPTH)) u_select (
        .clk(clk), .rst(rst),
        .char_req(char_req), .data_valid(data_valid), .data_byte(data_byte),
        .block_active(block_active), .qty(qty), .sync_char(rd_char),
        .ptr_clear(cfg_cnt_we), .rd_idx(rd_idx), .data_pop(data_pop),
        .fill_sync(fill_sync), .tx_valid(tx_valid), .tx_kind(kind),
        .tx_char(tx_char), .mark_flag(mark_idle_flag)
    );

    sfi_fill_counter #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .inc(fill_sync), .count(fill_count)
    );

    assign tx_kind = kind;
endmodule

// File: tb/sync_fill_inserter_tb.sv
`timescale 1ns/1ps
module sync_fill_inserter_tb;
    logic clk = 0, rst = 1;
    logic cfg_char_we = 0, cfg_cnt_we = 0, char_req = 0, block_active = 0, data_valid = 0;
    logic [1:0] cfg_char_idx = 0;
    logic [7:0] cfg_char = 0, data_byte = 0;
    logic [2:0] cfg_cnt = 0;
    logic data_pop, tx_valid, mark_idle_flag;
    logic [1:0] tx_kind;
    logic [7:0] tx_char, fill_count;

    always #2.5 clk = ~clk;

    sync_fill_inserter u_dut (
        .clk(clk), .rst(rst), .cfg_char_we(cfg_char_we), .cfg_char_idx(cfg_char_idx),
        .cfg_char(cfg_char), .cfg_cnt_we(cfg_cnt_we), .cfg_cnt(cfg_cnt),
        .char_req(char_req), .block_active(block_active), .data_valid(data_valid),
        .data_byte(data_byte), .data_pop(data_pop), .tx_valid(tx_valid),
        .tx_kind(tx_kind), .tx_char(tx_char), .mark_idle_flag(mark_idle_flag),
        .fill_count(fill_count)
    );

    typedef struct {
        logic v; logic [1:0] k; logic [7:0] c; logic [7:0] cnt; logic flag; string tag;
    } exp_t;
    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_tab [4];
    int m_n = 0, m_ptr = 0, m_cnt = 0;
    logic m_flag = 0;

    function automatic exp_t mk(logic v, logic [1:0] k, logic [7:0] c, string tag);
        exp_t e;
        e.v = v; e.k = k; e.c = c; e.cnt = 8'(m_cnt); e.flag = m_flag; e.tag = tag;
        return e;
    endfunction

    task automatic step(input logic req, input logic dv, input logic [7:0] db,
                        input logic act, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_char_we = 0; cfg_cnt_we = 0;
        char_req = req; data_valid = dv; data_byte = db; block_active = act;
        if (req && dv) begin
            m_ptr = 0;
            e = mk(1, 2'd1, db, tag);
        end else if (req && act && m_n == 0) begin
            m_flag = 1;
            e = mk(1, 2'd3, 8'hFF, tag);
        end else if (req && act) begin
            e.c = m_tab[m_ptr];
            m_ptr = (m_ptr + 1 >= m_n) ? 0 : m_ptr + 1;
            if (m_cnt < 255) m_cnt++;
            e = mk(1, 2'd2, e.c, tag);
        end else begin
            e = mk(0, 2'd0, 8'h00, tag);
        end
        q.push_back(e);
        #1;
        checks++;
        if (data_pop !== (req && dv)) begin
            errors++;
            $display("FAIL %s data_pop actual=%b expected=%b", tag, data_pop, req && dv);
        end
    endtask

    task automatic load_char(input int idx, input logic [7:0] c);
        @(negedge clk);
        char_req = 0; cfg_cnt_we = 0;
        cfg_char_we = 1; cfg_char_idx = 2'(idx); cfg_char = c;
        m_tab[idx] = c;
        q.push_back(mk(0, 2'd0, 8'h00, "R11"));
    endtask

    task automatic load_cnt(input int n);
        @(negedge clk);
        char_req = 0; cfg_char_we = 0;
        cfg_cnt_we = 1; cfg_cnt = 3'(n);
        m_n = (n > 4) ? 4 : n;
        m_ptr = 0;
        q.push_back(mk(0, 2'd0, 8'h00, "R12"));
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (tx_valid !== e.v || (e.v && (tx_kind !== e.k || tx_char !== e.c)) ||
                fill_count !== e.cnt || mark_idle_flag !== e.flag) begin
                errors++;
                $display("FAIL %s actual v=%b k=%0d c=%h cnt=%0d f=%b expected v=%b k=%0d c=%h cnt=%0d f=%b",
                         e.tag, tx_valid, tx_kind, tx_char, fill_count, mark_idle_flag,
                         e.v, e.k, e.c, e.cnt, e.flag);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        checks++;
        if (tx_valid !== 0 || fill_count !== 0 || mark_idle_flag !== 0) begin
            errors++;
            $display("FAIL R1 reset actual v=%b cnt=%0d f=%b expected v=0 cnt=0 f=0",
                     tx_valid, fill_count, mark_idle_flag);
        end
        load_char(0, 8'h16); load_char(1, 8'h32); load_char(2, 8'h7E); load_char(3, 8'h55);
        load_cnt(2);
        step(1, 1, 8'h41, 1, "R2");
        step(1, 1, 8'h16, 1, "R3");
        step(1, 1, 8'h10, 0, "R3");
        step(1, 0, 8'h00, 1, "R4");
        step(1, 0, 8'h00, 1, "R5");
        step(1, 0, 8'h00, 1, "R5");
        step(1, 1, 8'h03, 1, "R6");
        step(1, 0, 8'h00, 1, "R6");
        step(0, 0, 8'h00, 1, "R10");
        step(0, 1, 8'hAA, 1, "R10");
        step(1, 0, 8'h00, 0, "R7");
        load_cnt(4);
        for (int i = 0; i < 5; i++) step(1, 0, 8'h00, 1, "R5");
        load_cnt(7);
        for (int i = 0; i < 5; i++) step(1, 0, 8'h00, 1, "R12");
        load_cnt(0);
        step(1, 0, 8'h00, 1, "R8");
        step(1, 1, 8'h5A, 1, "R8");
        step(0, 0, 8'h00, 0, "R8");
        load_char(0, 8'h99);
        load_cnt(1);
        step(1, 0, 8'h00, 1, "R11");
        for (int i = 0; i < 260; i++) step(1, 0, 8'h00, 1, "R9");
        step(0, 0, 8'h00, 0, "R9");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule